// File: doc/BRIEF.md
# Column-Serial Min-Sum-3 LDPC Bit-Node Engine

This block runs an LDPC decoder one bit node at a time, column by column, instead of finishing a whole check-node layer first. Each operation names a bit node and supplies its channel LLR. The engine visits every check node wired to that bit and forms the check-to-bit messages. It then sums them with the channel value into the a posteriori value. From that value it derives the new bit-to-check messages and the extrinsic value that goes back to the demapper. Finally it rewrites the state of each visited check in place, so the very next bit already sees the updated state.

Each check node keeps a running parity of its incoming message signs. It also keeps its three smallest incoming magnitudes and the bit indices of the smallest two. Because of this, one edge can be replaced without rescanning the rest of the check's edges. The parity-check structure is a parameter: a table with one byte per (bit, slot) pair. To initialise a frame, each bit is first issued once with the load qualifier. After that, decode operations are issued in any bit order, for as many passes as the caller wants. The caller watches the hard decision to decide when to stop.

Top module: `ldpc_vl_node`

## Requirements
- R1: After synchronous reset, `done`=0, `ext`=0 and `hard`=0. Every check has parity 0, all three minima at 31 and no stored index. Every stored bit-to-check message is +0. A decode issued straight after reset therefore sees a message of +31 from each connected check.
- R2: A load operation (`load`=1) does the following:
  - It treats every check-to-bit message as 0 and stores the channel LLR as the bit-to-check message on each connected edge.
  - It XORs the LLR sign into each connected check's parity and inserts the LLR magnitude into that check's minima.
  - It finishes with `ext`=0 and `hard`=1 exactly when the LLR is negative.
- R3: In a decode operation, the message from check m to bit n has these parts:
  - Sign: the check parity XOR the sign of the stored message from n to m.
  - Magnitude: the second minimum when the first-minimum index equals n, otherwise the first minimum.
- R4: The a posteriori value T is the channel LLR plus the sum of the check-to-bit messages, clamped to ±127. The new bit-to-check message on each edge is T minus that edge's check-to-bit message, clamped to ±31. It is stored in sign-magnitude form, with the sign set only for values below zero.
- R5: `ext` is T minus the channel LLR, clamped to ±127, as 8-bit two's complement. `hard` is 1 exactly when T is below zero.
- R6: A decode flips a check's parity by the XOR of the old and new message signs on that edge.
- R7: Each decode updates a check's minima in two steps:
  - Remove bit n's old entry. If n held the first-minimum index, the second minimum and its index move to first, the third minimum moves to second, the second index becomes empty, and the third minimum keeps its value. If n held the second-minimum index, the third minimum moves to second and the second index becomes empty. Otherwise nothing is removed.
  - Insert the new magnitude with index n at the first position it is strictly smaller than. The entries below it move down one place.
  - Load operations skip the removal step.
- R8: `start` is taken only while the engine is idle. `done` pulses for one cycle on the (DV_MAX+2)-th rising edge after the edge that took `start`. `ext` and `hard` hold until the next pulse. A `start` raised while busy is dropped and produces no extra `done`.
- R9: The adjacency table has one byte per edge slot. The byte at offset (bit×DV_MAX+slot)×8 holds the check index in bits 6:0 and a valid flag in bit 7. A slot that is not valid, or whose index is at least N_CHK, adds nothing to T and changes no state.
- R10: `llr` is sign-magnitude: bit 5 is the sign and bits 4:0 the magnitude. The negative-zero code 6'b100000 behaves exactly like +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| load | input | 1 | 1: initialisation load, 0: decode |
| bit_idx | input | BIT_W | Bit node to process |
| llr | input | 6 | Channel LLR, sign-magnitude |
| done | output | 1 | One-cycle completion pulse |
| ext | output | 8 | Extrinsic value for the demapper, two's complement |
| hard | output | 1 | Hard decision (1 = negative a posteriori value) |

## Verification
The bench replays every frame against an arithmetic model of the algorithm. It sweeps ten channel-LLR patterns, each loaded and then decoded for four passes over every bit:
- Uniform strong positive and uniform strong negative LLRs exercise parity tracking and clamping of the new bit-to-check messages.
- Alternating signs show whether the parity is flipped on the correct edge.
- Equal magnitudes everywhere separate strict-less insertion from less-or-equal insertion, and show whether the second minimum is chosen by index rather than by value.
- Scattered values drive removal from the first, second and third positions.
- A negative-zero code checks that this code behaves as +0.

Single-slot bits show that absent slots are skipped, a decode issued straight from reset shows the reset minima, and a `start` raised mid-operation shows that it is dropped.

// File: rtl/ldpc_vl_pkg.sv
package ldpc_vl_pkg;

    localparam int MAG_W  = 5;
    localparam int MSG_W  = 6;
    localparam int POST_W = 8;
    localparam int IDX_W  = 8;
    localparam int WIDE_W = 16;

    localparam logic [IDX_W-1:0] IDX_NONE = '1;
    localparam logic [MAG_W-1:0] MAG_TOP  = '1;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } msg_t;

    typedef struct packed {
        logic             par;
        logic [MAG_W-1:0] m1;
        logic [MAG_W-1:0] m2;
        logic [MAG_W-1:0] m3;
        logic [IDX_W-1:0] i1;
        logic [IDX_W-1:0] i2;
    } chk_st_t;

    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic signed [MSG_W:0]    emsg_t;
    typedef logic signed [POST_W-1:0] post_t;

    localparam wide_t MSG_LIM  = 16'sd31;
    localparam wide_t POST_LIM = 16'sd127;

    localparam chk_st_t CHK_RESET = '{par: 1'b0, m1: MAG_TOP, m2: MAG_TOP,
                                      m3: MAG_TOP, i1: IDX_NONE, i2: IDX_NONE};

    // sign-magnitude to two's complement; negative zero maps to zero
    function automatic emsg_t sm2int(msg_t m);
        emsg_t u;
        u = emsg_t'({2'b00, m.mag});
        return m.neg ? -u : u;
    endfunction

    // clamp to +-31 and return normalised sign-magnitude
    function automatic msg_t sat_msg(wide_t v);
        msg_t  r;
        wide_t a;
        a     = v[WIDE_W-1] ? -v : v;
        r.neg = v[WIDE_W-1];
        r.mag = (a > MSG_LIM) ? MAG_TOP : a[MAG_W-1:0];
        return r;
    endfunction

    // clamp to +-127
    function automatic post_t sat_post(wide_t v);
        if (v > POST_LIM)       return 8'sd127;
        else if (v < -POST_LIM) return -8'sd127;
        else                    return v[POST_W-1:0];
    endfunction

endpackage

// File: rtl/ldpc_vl_edgemsg.sv
module ldpc_vl_edgemsg
    import ldpc_vl_pkg::*;
(
    input  chk_st_t          st,
    input  logic [IDX_W-1:0] bit_id,
    input  msg_t             old,
    input  logic             load,
    output emsg_t            e
);
    logic [MAG_W-1:0] mag;
    emsg_t            u;
    logic             neg;

    always_comb begin
        // R3: exclude own contribution by index, sign via parity
        mag = (st.i1 == bit_id) ? st.m2 : st.m1;
        u   = emsg_t'({2'b00, mag});
        neg = st.par ^ old.neg;
        e   = load ? '0 : (neg ? -u : u);
    end
endmodule

// File: rtl/ldpc_vl_minupd.sv
module ldpc_vl_minupd
    import ldpc_vl_pkg::*;
(
    input  chk_st_t          cur,
    input  logic [IDX_W-1:0] bit_id,
    input  logic             load,
    input  msg_t             oldm,
    input  msg_t             newm,
    output chk_st_t          nxt
);
    chk_st_t rem;

    // R7 step 1: drop the bit's old entry
    always_comb begin
        rem = cur;
        if (!load) begin
            if (cur.i1 == bit_id) begin
                rem.m1 = cur.m2;
                rem.i1 = cur.i2;
                rem.m2 = cur.m3;
                rem.i2 = IDX_NONE;
            end else if (cur.i2 == bit_id) begin
                rem.m2 = cur.m3;
                rem.i2 = IDX_NONE;
            end
        end
    end

    // R7 step 2: strict-less insertion; R6: parity update
    always_comb begin
        nxt     = rem;
        nxt.par = cur.par ^ (load ? 1'b0 : oldm.neg) ^ newm.neg;
        if (newm.mag < rem.m1) begin
            nxt.m3 = rem.m2;
            nxt.m2 = rem.m1;
            nxt.i2 = rem.i1;
            nxt.m1 = newm.mag;
            nxt.i1 = bit_id;
        end else if (newm.mag < rem.m2) begin
            nxt.m3 = rem.m2;
            nxt.m2 = newm.mag;
            nxt.i2 = bit_id;
        end else if (newm.mag < rem.m3) begin
            nxt.m3 = newm.mag;
        end
    end
endmodule

// File: rtl/ldpc_vl_node.sv
module ldpc_vl_node
    import ldpc_vl_pkg::*;
#(
    parameter int N_BITS = 6,
    parameter int N_CHK  = 3,
    parameter int DV_MAX = 2,
    parameter int BIT_W  = $clog2(N_BITS),
    parameter logic [N_BITS*DV_MAX*8-1:0] ADJ = 96'h8082_0081_0080_8281_8280_8180
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             load,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [5:0]       llr,
    output logic             done,
    output logic [7:0]       ext,
    output logic             hard
);
    localparam int N_EDGE = N_BITS * DV_MAX;
    localparam int TI_W   = $clog2(N_EDGE);
    localparam int CHK_W  = $clog2(N_CHK);
    localparam int CNT_W  = $clog2(DV_MAX + 1);
    localparam int SUM_W  = MSG_W + 2 + $clog2(DV_MAX + 1);
    localparam int LAT_W  = $clog2(DV_MAX + 4) + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_SUM, ST_WB} st_e;

    st_e                      state;
    logic [CNT_W-1:0]         slot;
    logic [BIT_W-1:0]         cur_bit;
    msg_t                     cur_llr;
    logic                     cur_load;
    logic signed [SUM_W-1:0]  acc;
    post_t                    tn;
    emsg_t                    e_reg [DV_MAX];
    chk_st_t                  chk   [N_CHK];
    msg_t                     tmsg  [N_EDGE];
    logic                     done_q, hard_q;
    post_t                    ext_q;

    // adjacency table unpacked (R9)
    logic [7:0] adj_tab [N_EDGE];
    for (genvar g = 0; g < N_EDGE; g++) begin : g_adj
        assign adj_tab[g] = ADJ[g*8 +: 8];
    end

    logic [TI_W-1:0] base_ti, acc_ti;
    logic [7:0]      acc_ent;
    logic [CHK_W-1:0] acc_c;
    logic            acc_valid;
    emsg_t           e_edge, e_now;
    emsg_t           llr_v;

    assign base_ti   = TI_W'(cur_bit) * TI_W'(DV_MAX);
    assign acc_ti    = base_ti + TI_W'(slot);
    assign acc_ent   = adj_tab[acc_ti];
    assign acc_c     = acc_ent[CHK_W-1:0];
    assign acc_valid = acc_ent[7] && (acc_ent[6:0] < 7'(N_CHK));
    assign llr_v     = sm2int(cur_llr);

    ldpc_vl_edgemsg u_edge (
        .st    (chk[acc_c]),
        .bit_id(IDX_W'(cur_bit)),
        .old   (tmsg[acc_ti]),
        .load  (cur_load),
        .e     (e_edge)
    );
    assign e_now = acc_valid ? e_edge : '0;

    // write-back datapath, one lane per slot
    logic [TI_W-1:0]  wb_ti    [DV_MAX];
    logic [CHK_W-1:0] wb_c     [DV_MAX];
    logic             wb_valid [DV_MAX];
    msg_t             new_t    [DV_MAX];
    chk_st_t          nxt_st   [DV_MAX];

    for (genvar s = 0; s < DV_MAX; s++) begin : g_wb
        logic [7:0] ent;
        assign wb_ti[s]    = base_ti + TI_W'(s);
        assign ent         = adj_tab[wb_ti[s]];
        assign wb_c[s]     = ent[CHK_W-1:0];
        assign wb_valid[s] = ent[7] && (ent[6:0] < 7'(N_CHK));
        assign new_t[s]    = sat_msg(wide_t'(tn) - wide_t'(e_reg[s]));

        ldpc_vl_minupd u_upd (
            .cur   (chk[wb_c[s]]),
            .bit_id(IDX_W'(cur_bit)),
            .load  (cur_load),
            .oldm  (tmsg[wb_ti[s]]),
            .newm  (new_t[s]),
            .nxt   (nxt_st[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            slot     <= '0;
            cur_bit  <= '0;
            cur_llr  <= '0;
            cur_load <= 1'b0;
            acc      <= '0;
            tn       <= '0;
            done_q   <= 1'b0;
            ext_q    <= '0;
            hard_q   <= 1'b0;
            for (int j = 0; j < DV_MAX; j++) e_reg[j] <= '0;
            for (int c = 0; c < N_CHK; c++)  chk[c]   <= CHK_RESET;
            for (int t = 0; t < N_EDGE; t++) tmsg[t]  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cur_bit  <= bit_idx;
                    cur_llr  <= msg_t'(llr);
                    cur_load <= load;
                    acc      <= SUM_W'(sm2int(msg_t'(llr)));
                    slot     <= '0;
                    state    <= ST_ACC;
                end
                ST_ACC: begin
                    for (int j = 0; j < DV_MAX - 1; j++) e_reg[j] <= e_reg[j+1];
                    e_reg[DV_MAX-1] <= e_now;
                    acc <= acc + SUM_W'(e_now);
                    if (slot == CNT_W'(DV_MAX - 1)) state <= ST_SUM;
                    else                            slot  <= slot + 1'b1;
                end
                ST_SUM: begin
                    tn    <= sat_post(wide_t'(acc));
                    state <= ST_WB;
                end
                default: begin
                    for (int s = 0; s < DV_MAX; s++) begin
                        if (wb_valid[s]) begin
                            chk[wb_c[s]]   <= nxt_st[s];
                            tmsg[wb_ti[s]] <= new_t[s];
                        end
                    end
                    done_q <= 1'b1;
                    ext_q  <= sat_post(wide_t'(tn) - wide_t'(llr_v));
                    hard_q <= tn[POST_W-1];
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    assign done = done_q;
    assign ext  = ext_q;
    assign hard = hard_q;

    // ---------------- assertions ----------------
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst)                          lat_cnt <= '0;
        else if (state == ST_IDLE && start) lat_cnt <= LAT_W'(1);
        else if (done_q)                  lat_cnt <= '0;
        else if (lat_cnt != '0)           lat_cnt <= lat_cnt + 1'b1;
    end

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> lat_cnt == LAT_W'(DV_MAX + 3));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_load_ext_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (done_q && cur_load) |-> ext_q == '0);

    for (genvar c = 0; c < N_CHK; c++) begin : g_chk_prop
        p_sorted_r7: assert property (@(posedge clk) disable iff (rst)
            (chk[c].m1 <= chk[c].m2) && (chk[c].m2 <= chk[c].m3));
        p_idx_distinct_r7: assert property (@(posedge clk) disable iff (rst)
            (chk[c].i1 != chk[c].i2) || (chk[c].i1 == IDX_NONE));
    end

endmodule

// File: tb/ldpc_vl_node_bench.sv
`timescale 1ns/1ps
module ldpc_vl_node_bench;
    localparam int NB = 6;
    localparam int NC = 3;
    localparam int DV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       load = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [5:0] llr = '0;
    logic       done;
    logic [7:0] ext;
    logic       hard;

    always #2 clk = ~clk;

    ldpc_vl_node u_ldpc_vl_node (
        .clk(clk), .rst(rst), .start(start), .load(load),
        .bit_idx(bit_idx), .llr(llr), .done(done), .ext(ext), .hard(hard)
    );

    int total = 0;
    int bad   = 0;

    // adjacency of the default configuration, -1 = empty slot (R9)
    int adjc [NB][DV] = '{'{0,1}, '{0,2}, '{1,2}, '{0,-1}, '{1,-1}, '{2,0}};

    int par [NC], m1 [NC], m2 [NC], m3 [NC], i1 [NC], i2 [NC];
    int tm  [NB][DV];

    function automatic int clampv(int v, int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int smval(logic [5:0] e);
        return e[5] ? -int'(e[4:0]) : int'(e[4:0]);
    endfunction

    function automatic logic [5:0] enc(int v);
        return (v < 0) ? {1'b1, 5'(-v)} : {1'b0, 5'(v)};
    endfunction

    function automatic logic [5:0] gen(int p, int b);
        int v;
        if (p == 4 && b == 2) return 6'b100000;   // negative zero (R10)
        case (p)
            0: v = 31;
            1: v = -31;
            2: v = (b % 2 != 0) ? -5 : 5;
            3: v = 7;
            default: v = ((p*13 + b*17 + 3) % 63) - 31;
        endcase
        return enc(v);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            par[c] = 0; m1[c] = 31; m2[c] = 31; m3[c] = 31; i1[c] = 255; i2[c] = 255;
        end
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < DV; s++) tm[b][s] = 0;
    endtask

    task automatic model_op(input int n, input int lv, input bit ld,
                            output int x_ext, output int x_hard);
        int e [DV];
        int sum, tnv, c, mag, nv, v;
        bit neg, oneg;
        sum = lv;
        for (int s = 0; s < DV; s++) begin
            c = adjc[n][s];
            e[s] = 0;
            if (c >= 0 && !ld) begin
                mag  = (i1[c] == n) ? m2[c] : m1[c];
                neg  = (par[c] != 0) ^ (tm[n][s] < 0);
                e[s] = neg ? -mag : mag;
            end
            sum += e[s];
        end
        tnv    = clampv(sum, 127);
        x_ext  = clampv(tnv - lv, 127);
        x_hard = (tnv < 0) ? 1 : 0;
        for (int s = 0; s < DV; s++) begin
            c = adjc[n][s];
            if (c >= 0) begin
                nv   = clampv(tnv - e[s], 31);
                oneg = ld ? 1'b0 : (tm[n][s] < 0);
                par[c] = par[c] ^ int'(oneg) ^ int'(nv < 0);
                if (!ld) begin
                    if (i1[c] == n) begin
                        m1[c] = m2[c]; i1[c] = i2[c]; m2[c] = m3[c]; i2[c] = 255;
                    end else if (i2[c] == n) begin
                        m2[c] = m3[c]; i2[c] = 255;
                    end
                end
                v = absv(nv);
                if (v < m1[c]) begin
                    m3[c] = m2[c]; m2[c] = m1[c]; i2[c] = i1[c]; m1[c] = v; i1[c] = n;
                end else if (v < m2[c]) begin
                    m3[c] = m2[c]; m2[c] = v; i2[c] = n;
                end else if (v < m3[c]) begin
                    m3[c] = v;
                end
                tm[n][s] = nv;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    task automatic run_op(input int n, input logic [5:0] code, input bit ld,
                          input bit poke, input string tag);
        int cnt, xe, xh, extra;
        @(negedge clk);
        start = 1'b1; load = ld; bit_idx = 3'(n); llr = code;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 50) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 1) begin
                start = 1'b1; load = 1'b1; bit_idx = 3'((n + 1) % NB); llr = 6'b011111;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        model_op(n, smval(code), ld, xe, xh);
        check(cnt == DV + 2, {tag, " R8 latency"}, cnt, DV + 2);
        check($signed(ext) == xe, {tag, " ext"}, $signed(ext), xe);
        check(int'(hard) == xh, {tag, " hard"}, int'(hard), xh);
        if (poke) begin
            extra = 0;
            for (int k = 0; k < DV + 3; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R8 busy start dropped", extra, 0);
        end
    endtask

    initial begin
        string tg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        // R1 reset state at the ports
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(ext == 8'd0,  "R1 ext after reset", int'(ext), 0);
        check(hard == 1'b0, "R1 hard after reset", int'(hard), 0);
        // R1: decode straight from reset sees +31 from the single check of bit 3
        run_op(3, 6'b000000, 1'b0, 1'b0, "R1/R9 reset minima");
        check($signed(ext) == 31, "R1 reset minima ext", $signed(ext), 31);

        for (int p = 0; p < 10; p++) begin
            do_reset();
            for (int b = 0; b < NB; b++) begin
                tg = (p == 4 && b == 2) ? "R2/R10 load" : "R2 load";
                run_op(b, gen(p, b), 1'b1, (p == 2 && b == 1), tg);
            end
            for (int it = 0; it < 4; it++) begin
                for (int b = 0; b < NB; b++) begin
                    tg = "R3/R4/R5/R6/R7 decode";
                    if (b == 3 || b == 4) tg = {tg, " R9"};
                    if (p == 4 && b == 2) tg = {tg, " R10"};
                    run_op(b, gen(p, b), 1'b0, (p == 5 && it == 1 && b == 2), tg);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule